// File: doc/BRIEF.md
# Data-Side Load/Store Unit with Permission-Fault Gating

This block sits between a processor pipeline and a data bus. It takes one load or store command at a time and turns it into word-aligned bus transactions. Each transaction uses a request/grant handshake for the address phase and a response-valid/error pair for the data phase. Loads and stores may be a byte, a halfword or a word wide, at any byte address. When an access crosses a word boundary, the unit issues two aligned transactions, one after the other. For a load it then joins the two returned words, moves the addressed bytes down to bit 0, and sign- or zero-extends the result.

An external permission checker looks at the outgoing bus address and returns a fault flag. While that flag is high, the unit keeps its request off the bus but behaves as though the request had been granted. It records the fault and moves straight on. If the access is split, that includes issuing the second half.

Bus errors and permission faults from either half are merged into one fault report. That report comes with the completion pulse, together with the original byte address, so the controller can raise an exception.

Top module: `lsu_gated`

## Requirements
- R1: After reset, `busy_o`, `dbus_req_o`, `done_o` and `done_fault_o` are all low.
- R2: An access that stays within one word produces exactly one bus transaction. That transaction carries:
  - the word-aligned address;
  - byte enables taken from the size code (0 = byte, 1 = halfword, 2 or 3 = word) shifted left by the low two address bits;
  - the store data shifted into those lanes, with disabled lanes zero.
- R3: A halfword at offset 3, or a word at offset 1 to 3, is split into two transactions in sequence: first the word holding the start address, then the next word. Each carries only its own byte enables and data lanes. The second request is not raised until the first response has arrived.
- R4: A load result is assembled from the addressed bytes, placed at bit 0, and sign-extended when `cmd_sext_i` is 1 (zero-extended otherwise). It appears on `done_rdata_o` with a one-cycle `done_o` pulse, in the cycle after the final response (or after the final permission-faulted request phase). A store reports zero data.
- R5: A bus error on either half raises `done_fault_o` with `done_o`, and `done_addr_o` holds the original unaligned address. An error on the first half does not stop the second half from being issued.
- R6: While `perm_fault_i` is high in a request phase, `dbus_req_o` stays low and the unit advances at once as if granted, without waiting for a response. The access completes with `done_fault_o` high and zero data.
- R7: A request stays asserted, with a stable address, until it is granted.
- R8: `busy_o` is high from the cycle after a command is accepted until `done_o` rises. Commands presented while busy are ignored.
- R9: `done_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Command present; taken when `busy_o` is low |
| cmd_we_i | input | 1 | 1 = store, 0 = load |
| cmd_size_i | input | 2 | 0 byte, 1 halfword, 2/3 word |
| cmd_sext_i | input | 1 | Sign-extend load result |
| cmd_addr_i | input | 32 | Byte address |
| cmd_wdata_i | input | 32 | Store data, right-aligned |
| perm_fault_i | input | 1 | Permission check result for `dbus_addr_o` |
| dbus_req_o | output | 1 | Bus request |
| dbus_gnt_i | input | 1 | Bus grant |
| dbus_addr_o | output | 32 | Word-aligned bus address |
| dbus_we_o | output | 1 | Bus write enable |
| dbus_be_o | output | 4 | Bus byte enables |
| dbus_wdata_o | output | 32 | Bus write data |
| dbus_rvalid_i | input | 1 | Response valid |
| dbus_rdata_i | input | 32 | Response read data |
| dbus_err_i | input | 1 | Response error |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | Completion pulse |
| done_rdata_o | output | 32 | Extended load data |
| done_fault_o | output | 1 | Access faulted |
| done_addr_o | output | 32 | Original byte address of the completed access |

## Verification
The bench targets three kinds of misaligned access:
- **Halfword at offset 3.** A unit that missed this split case would issue a single transaction with a byte enable lost off the top lane.
- **Word splits at every offset.** A mistake in lane shifting would show up as wrong bytes on the bus or in the reassembled result.
- **Errors on either half.** A unit that abandoned the access after a first-half error would never raise the second request.

Permission faults are placed on the first half, on the second half, on both halves, and on an aligned store. A design that leaked the request onto the bus, or waited for a response that never comes, is caught either by a request-line mismatch or by the completion pulse never arriving.

Grant and response delays are varied. Spurious commands are driven while the unit is busy, to expose an address that moves before the grant or a second command slipping in.

// File: rtl/lsu_gated_pkg.sv
package lsu_gated_pkg;

    localparam int unsigned XLEN  = 32;
    localparam int unsigned LANES = XLEN / 8;
    localparam int unsigned OFFW  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT
    } lsu_state_e;

    typedef struct packed {
        logic             we;
        acc_size_e        size;
        logic             sext;
        logic [XLEN-1:0]  addr;
        logic [XLEN-1:0]  wdata;
    } lsu_cmd_t;

    function automatic int unsigned size_bytes(acc_size_e s);
        case (s)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            default: return LANES;
        endcase
    endfunction

    function automatic logic [LANES-1:0] size_mask(acc_size_e s);
        case (s)
            SZ_BYTE: return LANES'(1);
            SZ_HALF: return LANES'(3);
            default: return '1;
        endcase
    endfunction

    function automatic logic crosses_word(acc_size_e s, logic [OFFW-1:0] off);
        return (int'(off) + int'(size_bytes(s))) > int'(LANES);
    endfunction

endpackage

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
    import lsu_gated_pkg::*;
(
    input  acc_size_e         size_i,
    input  logic [OFFW-1:0]   off_i,
    input  logic              hi_part_i,
    input  logic [XLEN-1:0]   wdata_i,
    output logic [LANES-1:0]  be_o,
    output logic [XLEN-1:0]   wdata_o
);
    logic [2*LANES-1:0] be_wide;
    logic [2*XLEN-1:0]  wd_wide;

    always_comb begin
        be_wide = {{LANES{1'b0}}, size_mask(size_i)} << off_i;
        wd_wide = {{XLEN{1'b0}}, wdata_i} << {off_i, 3'b000};
        if (hi_part_i) begin
            be_o    = be_wide[2*LANES-1:LANES];
            wdata_o = wd_wide[2*XLEN-1:XLEN];
        end else begin
            be_o    = be_wide[LANES-1:0];
            wdata_o = wd_wide[XLEN-1:0];
        end
    end
endmodule

// File: rtl/lsu_load_merge.sv
module lsu_load_merge
    import lsu_gated_pkg::*;
(
    input  logic [XLEN-1:0]  lo_i,
    input  logic [XLEN-1:0]  hi_i,
    input  acc_size_e        size_i,
    input  logic [OFFW-1:0]  off_i,
    input  logic             sext_i,
    output logic [XLEN-1:0]  data_o
);
    logic [XLEN-1:0] aligned;

    always_comb begin
        aligned = XLEN'({hi_i, lo_i} >> {off_i, 3'b000});
        case (size_i)
            SZ_BYTE: data_o = {{(XLEN-8){sext_i & aligned[7]}},   aligned[7:0]};
            SZ_HALF: data_o = {{(XLEN-16){sext_i & aligned[15]}}, aligned[15:0]};
            default: data_o = aligned;
        endcase
    end
endmodule

// File: rtl/lsu_gated.sv
module lsu_gated
    import lsu_gated_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid_i,
    input  logic              cmd_we_i,
    input  logic [1:0]        cmd_size_i,
    input  logic              cmd_sext_i,
    input  logic [XLEN-1:0]   cmd_addr_i,
    input  logic [XLEN-1:0]   cmd_wdata_i,
    input  logic              perm_fault_i,
    output logic              dbus_req_o,
    input  logic              dbus_gnt_i,
    output logic [XLEN-1:0]   dbus_addr_o,
    output logic              dbus_we_o,
    output logic [LANES-1:0]  dbus_be_o,
    output logic [XLEN-1:0]   dbus_wdata_o,
    input  logic              dbus_rvalid_i,
    input  logic [XLEN-1:0]   dbus_rdata_i,
    input  logic              dbus_err_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [XLEN-1:0]   done_rdata_o,
    output logic              done_fault_o,
    output logic [XLEN-1:0]   done_addr_o
);
    localparam int unsigned WORDW = XLEN - OFFW;

    lsu_state_e      state_q;
    lsu_cmd_t        cmd_q;
    logic            part_q;
    logic            err_q;
    logic            perm_q;
    logic [XLEN-1:0] lo_q;
    logic            done_q;
    logic            fault_q;
    logic [XLEN-1:0] rdata_q;
    logic [XLEN-1:0] faddr_q;

    logic            split;
    logic            last_part;
    logic [WORDW-1:0] word_sel;
    logic [XLEN-1:0] merged;

    assign split     = crosses_word(cmd_q.size, cmd_q.addr[OFFW-1:0]);
    assign last_part = !split || part_q;
    assign word_sel  = cmd_q.addr[XLEN-1:OFFW] + WORDW'(part_q);

    assign dbus_req_o  = (state_q == ST_REQ) && !perm_fault_i;
    assign dbus_addr_o = {word_sel, {OFFW{1'b0}}};
    assign dbus_we_o   = cmd_q.we;
    assign busy_o      = (state_q != ST_IDLE);

    assign done_o       = done_q;
    assign done_fault_o = done_q & fault_q;
    assign done_rdata_o = rdata_q;
    assign done_addr_o  = faddr_q;

    lsu_lane_align u_align (
        .size_i    (cmd_q.size),
        .off_i     (cmd_q.addr[OFFW-1:0]),
        .hi_part_i (part_q),
        .wdata_i   (cmd_q.wdata),
        .be_o      (dbus_be_o),
        .wdata_o   (dbus_wdata_o)
    );

    lsu_load_merge u_merge (
        .lo_i   (split ? lo_q : dbus_rdata_i),
        .hi_i   (dbus_rdata_i),
        .size_i (cmd_q.size),
        .off_i  (cmd_q.addr[OFFW-1:0]),
        .sext_i (cmd_q.sext),
        .data_o (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cmd_q   <= '0;
            part_q  <= 1'b0;
            err_q   <= 1'b0;
            perm_q  <= 1'b0;
            lo_q    <= '0;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            rdata_q <= '0;
            faddr_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (cmd_valid_i) begin
                        cmd_q.we    <= cmd_we_i;
                        cmd_q.size  <= acc_size_e'(cmd_size_i);
                        cmd_q.sext  <= cmd_sext_i;
                        cmd_q.addr  <= cmd_addr_i;
                        cmd_q.wdata <= cmd_wdata_i;
                        part_q      <= 1'b0;
                        err_q       <= 1'b0;
                        perm_q      <= 1'b0;
                        state_q     <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (perm_fault_i) begin
                        perm_q <= 1'b1;
                        if (last_part) begin
                            done_q  <= 1'b1;
                            fault_q <= 1'b1;
                            rdata_q <= '0;
                            faddr_q <= cmd_q.addr;
                            state_q <= ST_IDLE;
                        end else begin
                            part_q <= 1'b1;
                        end
                    end else if (dbus_gnt_i) begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (dbus_rvalid_i) begin
                        if (!last_part) begin
                            lo_q    <= dbus_rdata_i;
                            err_q   <= err_q | dbus_err_i;
                            part_q  <= 1'b1;
                            state_q <= ST_REQ;
                        end else begin
                            done_q  <= 1'b1;
                            fault_q <= perm_q | err_q | dbus_err_i;
                            rdata_q <= (perm_q | err_q | dbus_err_i | cmd_q.we) ? '0 : merged;
                            faddr_q <= cmd_q.addr;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        dbus_req_o && !dbus_gnt_i |=> (dbus_req_o || perm_fault_i) && $stable(dbus_addr_o)); // R7

    AST_NO_REQ_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
        perm_fault_i |-> !dbus_req_o); // R6

    AST_ALIGNED_BUS: assert property (@(posedge clk) disable iff (rst)
        dbus_req_o |-> (dbus_addr_o[OFFW-1:0] == '0) && (dbus_be_o != '0)); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R9

    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o); // R8

endmodule

// File: tb/lsu_gated_bench.sv
module lsu_gated_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0, cmd_we = 1'b0, cmd_sext = 1'b0;
    logic [1:0]  cmd_size = 2'd0;
    logic [31:0] cmd_addr = '0, cmd_wdata = '0;
    logic        perm_fault;
    logic        dbus_req, dbus_gnt = 1'b0, dbus_we;
    logic [31:0] dbus_addr, dbus_wdata, dbus_rdata = '0;
    logic [3:0]  dbus_be;
    logic        dbus_rvalid = 1'b0, dbus_err = 1'b0;
    logic        busy, done, done_fault;
    logic [31:0] done_rdata, done_addr;

    logic        pm0 = 1'b0, pm1 = 1'b0;
    logic [29:0] pw0 = '0, pw1 = '0;
    assign perm_fault = (pm0 && dbus_addr[31:2] == pw0) || (pm1 && dbus_addr[31:2] == pw1);

    logic [31:0] mem [16];
    int vectors = 0;
    int errors  = 0;

    always #4 clk = ~clk;

    lsu_gated u_lsu_gated (
        .clk(clk), .rst(rst),
        .cmd_valid_i(cmd_valid), .cmd_we_i(cmd_we), .cmd_size_i(cmd_size),
        .cmd_sext_i(cmd_sext), .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata),
        .perm_fault_i(perm_fault),
        .dbus_req_o(dbus_req), .dbus_gnt_i(dbus_gnt), .dbus_addr_o(dbus_addr),
        .dbus_we_o(dbus_we), .dbus_be_o(dbus_be), .dbus_wdata_o(dbus_wdata),
        .dbus_rvalid_i(dbus_rvalid), .dbus_rdata_i(dbus_rdata), .dbus_err_i(dbus_err),
        .busy_o(busy), .done_o(done), .done_rdata_o(done_rdata),
        .done_fault_o(done_fault), .done_addr_o(done_addr)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic we, input logic [1:0] sz, input logic sx,
                         input logic [31:0] a, input logic [31:0] wd,
                         input int gd, input int rd,
                         input logic [1:0] errm, input logic [1:0] pmm, input logic noise);
        int nb, np, k, ph, cnt;
        logic split, fin, exp_fault;
        logic [31:0] exp_rd, ba, wk;
        logic [3:0]  ebe [2];
        logic [31:0] ewd [2];
        nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        split = (int'(a[1:0]) + nb) > 4;
        np = split ? 2 : 1;
        for (int p = 0; p < 2; p++) begin
            ebe[p] = '0; ewd[p] = '0;
            for (int i = 0; i < nb; i++) begin
                ba = a + 32'(i);
                if (ba[31:2] == a[31:2] + 30'(p)) begin
                    ebe[p][ba[1:0]] = 1'b1;
                    ewd[p][8*ba[1:0] +: 8] = wd[8*i +: 8];
                end
            end
        end
        exp_rd = '0;
        for (int i = 0; i < nb; i++) begin
            ba = a + 32'(i);
            exp_rd[8*i +: 8] = mem[ba[5:2]][8*ba[1:0] +: 8];
        end
        if (sx && nb < 4)
            for (int b = nb * 8; b < 32; b++) exp_rd[b] = exp_rd[nb*8-1];
        exp_fault = 1'b0;
        for (int p = 0; p < np; p++) exp_fault = exp_fault | pmm[p] | errm[p];
        if (exp_fault || we) exp_rd = '0;
        pw0 = a[31:2]; pw1 = a[31:2] + 30'd1;
        pm0 = pmm[0];  pm1 = split & pmm[1];

        @(negedge clk);
        while (busy) @(negedge clk);
        cmd_valid = 1'b1; cmd_we = we; cmd_size = sz; cmd_sext = sx;
        cmd_addr = a; cmd_wdata = wd;
        k = 0; ph = 0; cnt = 0; fin = 1'b0;
        for (int cyc = 0; cyc < 80 && !fin; cyc++) begin
            @(negedge clk);
            dbus_gnt = 1'b0; dbus_rvalid = 1'b0; dbus_err = 1'b0; dbus_rdata = '0;
            cmd_valid = noise; cmd_addr = 32'h0000_003D; cmd_size = 2'd2;
            if (ph == 2) begin
                cmd_valid = 1'b0;
                chk(done == 1'b1, "R4 done pulse", 32'(done), 32'd1);
                chk(done_rdata == exp_rd, "R4 load data", done_rdata, exp_rd);
                chk(done_fault == exp_fault, "R5/R6 fault flag", 32'(done_fault), 32'(exp_fault));
                chk(done_addr == a, "R5 fault address", done_addr, a);
                chk(busy == 1'b0, "R8 idle at done", 32'(busy), 32'd0);
                fin = 1'b1;
            end else if (ph == 0) begin
                chk(busy == 1'b1, "R8 busy during access", 32'(busy), 32'd1);
                if (pmm[k]) begin
                    chk(dbus_req == 1'b0, "R6 request suppressed", 32'(dbus_req), 32'd0);
                    k++;
                    if (k == np) ph = 2;
                end else begin
                    wk = {a[31:2] + 30'(k), 2'b00};
                    chk(dbus_req == 1'b1, "R7 request held", 32'(dbus_req), 32'd1);
                    chk(dbus_addr == wk, "R3 part address", dbus_addr, wk);
                    chk(dbus_be == ebe[k], "R2 byte enables", 32'(dbus_be), 32'(ebe[k]));
                    chk(dbus_we == we, "R2 write enable", 32'(dbus_we), 32'(we));
                    if (we) chk(dbus_wdata == ewd[k], "R2 store lanes", dbus_wdata, ewd[k]);
                    if (cnt == gd) begin dbus_gnt = 1'b1; ph = 1; cnt = 0; end
                    else cnt++;
                end
            end else begin
                chk(dbus_req == 1'b0, "R3 one outstanding", 32'(dbus_req), 32'd0);
                if (cnt == rd) begin
                    wk = a + 32'(4 * k);
                    dbus_rvalid = 1'b1;
                    dbus_rdata  = mem[wk[5:2]];
                    dbus_err    = errm[k];
                    if (we && !errm[k])
                        for (int l = 0; l < 4; l++)
                            if (ebe[k][l]) mem[wk[5:2]][8*l +: 8] = ewd[k][8*l +: 8];
                    k++; cnt = 0;
                    ph = (k == np) ? 2 : 0;
                end else cnt++;
            end
        end
        if (!fin) chk(1'b0, "R4 completion never seen", 32'(done), 32'd1);
        @(negedge clk);
        chk(done == 1'b0, "R9 single-cycle done", 32'(done), 32'd0);
        pm0 = 1'b0; pm1 = 1'b0;
    endtask

    initial begin
        for (int c = 0; c < 200000; c++) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'h8F7E_6D5C + 32'(i) * 32'h0101_0101;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        chk(busy == 1'b0 && dbus_req == 1'b0 && done == 1'b0 && done_fault == 1'b0,
            "R1 reset state", {28'd0, busy, dbus_req, done, done_fault}, 32'd0);
        // R2/R4 aligned word, signed byte, unsigned byte, aligned half
        do_op(0, 2'd2, 0, 32'h10, 0, 0, 0, 2'b00, 2'b00, 0);
        do_op(0, 2'd0, 1, 32'h13, 0, 1, 2, 2'b00, 2'b00, 0);
        do_op(0, 2'd0, 0, 32'h13, 0, 0, 0, 2'b00, 2'b00, 0);
        do_op(0, 2'd1, 1, 32'h16, 0, 0, 1, 2'b00, 2'b00, 0);
        // R3 splits: half at offset 3, word at offsets 1..3
        do_op(0, 2'd1, 1, 32'h17, 0, 0, 0, 2'b00, 2'b00, 0);
        do_op(0, 2'd2, 0, 32'h21, 0, 2, 1, 2'b00, 2'b00, 1);
        do_op(0, 2'd3, 0, 32'h22, 0, 0, 0, 2'b00, 2'b00, 0);
        do_op(0, 2'd2, 0, 32'h27, 0, 1, 0, 2'b00, 2'b00, 0);
        // R2/R3 stores, then read back
        do_op(1, 2'd2, 0, 32'h0A, 32'hCAFE_F00D, 0, 0, 2'b00, 2'b00, 1);
        do_op(0, 2'd2, 0, 32'h0A, 0, 0, 0, 2'b00, 2'b00, 0);
        do_op(1, 2'd1, 0, 32'h31, 32'h0000_A55A, 1, 1, 2'b00, 2'b00, 0);
        do_op(0, 2'd1, 0, 32'h31, 0, 0, 0, 2'b00, 2'b00, 0);
        // R5 errors on each half
        do_op(0, 2'd2, 0, 32'h1D, 0, 0, 1, 2'b01, 2'b00, 0);
        do_op(0, 2'd1, 1, 32'h2B, 0, 1, 0, 2'b10, 2'b00, 0);
        // R6 permission faults
        do_op(0, 2'd2, 0, 32'h15, 0, 0, 0, 2'b00, 2'b01, 0);
        do_op(0, 2'd2, 0, 32'h16, 0, 0, 0, 2'b00, 2'b10, 1);
        do_op(0, 2'd2, 0, 32'h17, 0, 0, 0, 2'b00, 2'b11, 0);
        do_op(1, 2'd2, 0, 32'h20, 32'h1234_5678, 0, 0, 2'b00, 2'b01, 0);
        do_op(0, 2'd2, 0, 32'h20, 0, 0, 0, 2'b00, 2'b00, 0);
        // R7/R8 long grant stall with spurious commands
        do_op(0, 2'd0, 1, 32'h3E, 0, 4, 3, 2'b00, 2'b00, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule